// File: doc/BRIEF.md
# Per-Core Block Occupancy Governor

This controller lives beside one compute core and decides how many thread blocks the core may run at once. It holds a limit `n` that stays between 1 and a ceiling `MAX_BLK`. Two saturating event counters are fed by the pipeline. One counts cycles where the pipeline could issue but had nothing ready. The other counts cycles where every warp on the core was waiting for memory data. At the end of every fixed sampling window the controller sorts the two counts into a raise, lower or hold verdict, updates the limit, and clears both counters.

The limit is never lowered by removing work from the core. When the limit drops below the number of running blocks, the controller pulses `pause_blk` once per cycle. Each pulse tells the warp selector to deprioritise the most recently dispatched block that is still running. When a raise arrives while paused blocks exist, the controller pulses `resume_blk` so that the most recently paused block runs again, and no new block is requested. The global dispatcher reads `limit_n` to decide whether to send fresh blocks. A `kernel_start` pulse reloads the limit with half the ceiling.

Top module: `occ_limit_ctrl`

## Requirements
- R1: After reset, and in the cycle after a `kernel_start` pulse, `limit_n` equals max(1, floor(MAX_BLK/2)), which is 4 for the default ceiling of 8. The same event clears the window timer, both counters and the internal paused-block count.
- R2: Each event counter is CNT_W (11) bits wide. It adds one for each cycle its event input is high and holds at 2047 instead of wrapping. At each window end it restarts from the event of that final cycle.
- R3: `win_tick` is high for exactly one cycle in every WIN_LEN (2048) cycles, in the last cycle of each window. `limit_n` changes only in the cycle after a `win_tick` or after a `kernel_start`.
- R4: At a window end the verdict is raise when the idle count is at least 16. Otherwise it is raise when the memory-wait count is below 128. Otherwise it is lower when the memory-wait count is at least 384. In every other case it is hold.
- R5: On a raise while paused blocks exist, `resume_blk` is high in the `win_tick` cycle, the paused count drops by one, and the limit goes up by one.
- R6: A raise increases the limit only while it is below MAX_BLK; at MAX_BLK it is left unchanged.
- R7: A lower decreases the limit only while it is above 1; at 1 it is left unchanged.
- R8: In any cycle that is neither a `win_tick` nor a `kernel_start` cycle, `pause_blk` is high exactly when `resident_cnt` minus the paused count exceeds `limit_n`. Each pulse adds one to the paused count.
- R9: `pause_blk` and `resume_blk` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kernel_start | input | 1 | One-cycle pulse when a new kernel begins |
| idle_evt | input | 1 | Pipeline free but no warp ready this cycle |
| memwait_evt | input | 1 | Every warp waiting on memory this cycle |
| resident_cnt | input | BLK_W (4) | Blocks currently resident on the core |
| limit_n | output | BLK_W (4) | Allowed concurrent blocks |
| win_tick | output | 1 | Decision pulse at the last cycle of a window |
| pause_blk | output | 1 | Pause the most recent running block |
| resume_blk | output | 1 | Resume the most recently paused block |

## Verification
The checker watches every cycle for these properties: the limit stays within 1 to MAX_BLK, it moves only at a decision or a kernel start and then by at most one step, its reload value after a start is correct, counters saturate and step correctly, pause pulses occur only when running blocks exceed the limit and never on a decision cycle, resumes occur only on decision cycles, and the two commands never coincide. Whether the right verdict was reached from a given pair of window counts can only be shown by the bench. The same holds for threshold boundaries at 15/16, 127/128 and 383/384, and for the count of pause and resume pulses after a sequence of lowers and raises. The bench also shows the difference between saturation and wrap in a fully loaded window, and that a kernel start in mid-window discards partial counts.

// File: rtl/occ_pkg.sv
package occ_pkg;

    typedef enum logic [1:0] {
        VERDICT_HOLD  = 2'd0,
        VERDICT_RAISE = 2'd1,
        VERDICT_LOWER = 2'd2
    } verdict_e;

    localparam int EV_IDLE = 0;
    localparam int EV_MEM  = 1;
    localparam int EV_NUM  = 2;

    function automatic int start_limit(input int ceiling);
        return (ceiling / 2 < 1) ? 1 : ceiling / 2;
    endfunction

endpackage

// File: rtl/occ_evt_counter.sv
module occ_evt_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         wrap,
    input  logic         evt,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (wrap) begin
            cnt_d = {{(W-1){1'b0}}, evt};
        end else if (evt && (cnt_q != TOP)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/occ_win_timer.sv
module occ_win_timer #(
    parameter int WIN = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int TW = (WIN > 2) ? $clog2(WIN) : 1;
    localparam logic [TW-1:0] LAST = TW'(WIN - 1);

    logic [TW-1:0] pos_d, pos_q;

    assign tick = (pos_q == LAST);

    always_comb begin
        pos_d = pos_q + TW'(1);
        if (restart || tick) begin
            pos_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

endmodule

// File: rtl/occ_classifier.sv
module occ_classifier
    import occ_pkg::*;
#(
    parameter int W       = 11,
    parameter int T_IDLE  = 16,
    parameter int T_MEM_L = 128,
    parameter int T_MEM_H = 384
) (
    input  logic [W-1:0] idle_cnt,
    input  logic [W-1:0] mem_cnt,
    output verdict_e     verdict
);
    localparam logic [W-1:0] IDLE_V  = W'(T_IDLE);
    localparam logic [W-1:0] MEM_L_V = W'(T_MEM_L);
    localparam logic [W-1:0] MEM_H_V = W'(T_MEM_H);

    always_comb begin
        if (idle_cnt >= IDLE_V) begin
            verdict = VERDICT_RAISE;
        end else if (mem_cnt < MEM_L_V) begin
            verdict = VERDICT_RAISE;
        end else if (mem_cnt >= MEM_H_V) begin
            verdict = VERDICT_LOWER;
        end else begin
            verdict = VERDICT_HOLD;
        end
    end

endmodule

// File: rtl/occ_limit_ctrl.sv
module occ_limit_ctrl
    import occ_pkg::*;
#(
    parameter int MAX_BLK = 8,
    parameter int CNT_W   = 11,
    parameter int WIN_LEN = 2048,
    parameter int T_IDLE  = 16,
    parameter int T_MEM_L = 128,
    parameter int T_MEM_H = 384,
    parameter int BLK_W   = $clog2(MAX_BLK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kernel_start,
    input  logic             idle_evt,
    input  logic             memwait_evt,
    input  logic [BLK_W-1:0] resident_cnt,
    output logic [BLK_W-1:0] limit_n,
    output logic             win_tick,
    output logic             pause_blk,
    output logic             resume_blk
);
    localparam logic [BLK_W-1:0] CEIL  = BLK_W'(MAX_BLK);
    localparam logic [BLK_W-1:0] FLOOR = BLK_W'(1);
    localparam logic [BLK_W-1:0] INIT  = BLK_W'(start_limit(MAX_BLK));

    typedef struct packed {
        logic [BLK_W-1:0] lim;
        logic [BLK_W-1:0] paused;
        logic             pause;
        logic             resume;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [EV_NUM-1:0] evt_vec;
    logic [CNT_W-1:0]  cnt_arr [EV_NUM];
    logic [BLK_W-1:0]  running;
    verdict_e          verdict;

    assign evt_vec[EV_IDLE] = idle_evt;
    assign evt_vec[EV_MEM]  = memwait_evt;

    occ_win_timer #(.WIN(WIN_LEN)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (kernel_start),
        .tick    (win_tick)
    );

    for (genvar g = 0; g < EV_NUM; g++) begin : g_cnt
        occ_evt_counter #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (kernel_start),
            .wrap    (win_tick),
            .evt     (evt_vec[g]),
            .count   (cnt_arr[g])
        );
    end

    occ_classifier #(
        .W       (CNT_W),
        .T_IDLE  (T_IDLE),
        .T_MEM_L (T_MEM_L),
        .T_MEM_H (T_MEM_H)
    ) u_cls (
        .idle_cnt (cnt_arr[EV_IDLE]),
        .mem_cnt  (cnt_arr[EV_MEM]),
        .verdict  (verdict)
    );

    assign running = (resident_cnt >= st_q.paused) ? (resident_cnt - st_q.paused) : '0;

    always_comb begin
        st_d        = st_q;
        st_d.pause  = 1'b0;
        st_d.resume = 1'b0;
        if (kernel_start) begin
            st_d.lim    = INIT;
            st_d.paused = '0;
        end else if (win_tick) begin
            unique case (verdict)
                VERDICT_RAISE: begin
                    if (st_q.lim < CEIL) begin
                        st_d.lim = st_q.lim + BLK_W'(1);
                        if (st_q.paused != '0) begin
                            st_d.paused = st_q.paused - BLK_W'(1);
                            st_d.resume = 1'b1;
                        end
                    end
                end
                VERDICT_LOWER: begin
                    if (st_q.lim > FLOOR) begin
                        st_d.lim = st_q.lim - BLK_W'(1);
                    end
                end
                default: begin
                end
            endcase
        end else if (st_q.paused > resident_cnt) begin
            st_d.paused = resident_cnt;
        end else if (running > st_q.lim) begin
            st_d.paused = st_q.paused + BLK_W'(1);
            st_d.pause  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lim    <= INIT;
            st_q.paused <= '0;
            st_q.pause  <= 1'b0;
            st_q.resume <= 1'b0;
        end else begin
            st_q.lim    <= st_d.lim;
            st_q.paused <= st_d.paused;
            st_q.pause  <= 1'b0;
            st_q.resume <= 1'b0;
        end
    end

    assign limit_n    = st_q.lim;
    assign pause_blk  = st_d.pause;
    assign resume_blk = st_d.resume;

endmodule

// File: rtl/occ_limit_chk.sv
module occ_limit_chk #(
    parameter int MAX_BLK = 8,
    parameter int BLK_W   = 4,
    parameter int CNT_W   = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             kernel_start,
    input logic             idle_evt,
    input logic             win_tick,
    input logic             pause_blk,
    input logic             resume_blk,
    input logic [BLK_W-1:0] resident_cnt,
    input logic [BLK_W-1:0] limit_n,
    input logic [BLK_W-1:0] paused_cnt,
    input logic [CNT_W-1:0] idle_cnt,
    input logic [CNT_W-1:0] mem_cnt
);
    localparam int INIT_LIM = (MAX_BLK / 2 < 1) ? 1 : MAX_BLK / 2;
    localparam logic [CNT_W-1:0] TOP = '1;

    a_r7_limit_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(limit_n) >= 1) && (int'(limit_n) <= MAX_BLK));

    a_r1_start_reload: assert property (@(posedge clk) disable iff (!rst_n)
        kernel_start |=> (int'(limit_n) == INIT_LIM));

    a_r3_limit_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!kernel_start && !win_tick) |=> $stable(limit_n));

    a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        win_tick |=> !win_tick);

    a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (win_tick && !kernel_start) |=>
            (int'(limit_n) - int'($past(limit_n)) <= 1) &&
            (int'($past(limit_n)) - int'(limit_n) <= 1));

    a_r2_idle_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt == TOP && !win_tick && !kernel_start) |=> (idle_cnt == TOP));

    a_r2_mem_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cnt == TOP && !win_tick && !kernel_start) |=> (mem_cnt == TOP));

    a_r2_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_evt && idle_cnt != TOP && !win_tick && !kernel_start) |=>
            (idle_cnt == $past(idle_cnt) + CNT_W'(1)));

    a_r5_resume_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        resume_blk |-> win_tick);

    a_r8_pause_cause: assert property (@(posedge clk) disable iff (!rst_n)
        pause_blk |-> (!win_tick &&
            (int'(resident_cnt) > int'(limit_n) + int'(paused_cnt))));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pause_blk && resume_blk));

endmodule

bind occ_limit_ctrl occ_limit_chk #(
    .MAX_BLK (MAX_BLK),
    .BLK_W   (BLK_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .kernel_start (kernel_start),
    .idle_evt     (idle_evt),
    .win_tick     (win_tick),
    .pause_blk    (pause_blk),
    .resume_blk   (resume_blk),
    .resident_cnt (resident_cnt),
    .limit_n      (limit_n),
    .paused_cnt   (st_q.paused),
    .idle_cnt     (cnt_arr[0]),
    .mem_cnt      (cnt_arr[1])
);

// File: tb/sim_occ_limit_ctrl.sv
`timescale 1ns/1ps
module sim_occ_limit_ctrl;
    localparam int WIN   = 2048;
    localparam int BLK_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             kernel_start = 1'b0;
    logic             idle_evt = 1'b0;
    logic             memwait_evt = 1'b0;
    logic [BLK_W-1:0] resident_cnt = '0;
    logic [BLK_W-1:0] limit_n;
    logic             win_tick, pause_blk, resume_blk;

    int n_chk = 0, n_fail = 0;
    int p_tot = 0, r_tot = 0, t_tot = 0, both_tot = 0;
    bit done = 0;
    int tick_last;

    always #4 clk = ~clk;

    occ_limit_ctrl u0 (
        .clk (clk), .rst_n (rst_n), .kernel_start (kernel_start),
        .idle_evt (idle_evt), .memwait_evt (memwait_evt),
        .resident_cnt (resident_cnt), .limit_n (limit_n),
        .win_tick (win_tick), .pause_blk (pause_blk), .resume_blk (resume_blk)
    );

    // pulse monitor, samples one ns after the falling edge
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (pause_blk)  p_tot++;
            if (resume_blk) r_tot++;
            if (win_tick)   t_tot++;
            if (pause_blk && resume_blk) both_tot++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one full window; event inputs high for the first k cycles
    task automatic run_window(input int idle_k, input int mem_k, input int res,
                              output int pauses, output int resumes);
        int p0 = p_tot, r0 = r_tot, t0 = t_tot;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            kernel_start = 1'b0;
            resident_cnt = BLK_W'(res);
            idle_evt     = (i < idle_k);
            memwait_evt  = (i < mem_k);
            if (i == WIN - 1) begin
                #1;
                tick_last = int'(win_tick);
            end
            @(posedge clk);
        end
        #2;
        pauses  = p_tot - p0;
        resumes = r_tot - r0;
        chk("R3 tick in last cycle", tick_last, 1);
        chk("R3 ticks per window", t_tot - t0, 1);
    endtask

    task automatic start_kernel();
        @(negedge clk);
        kernel_start = 1'b1;
        idle_evt     = 1'b0;
        memwait_evt  = 1'b0;
        resident_cnt = '0;
        @(posedge clk);
        #2;
        chk("R1 limit after kernel start", int'(limit_n), 4);
    endtask

    // idle_k, mem_k, resident, exp_limit, exp_pauses, exp_resumes, req
    localparam int NV = 15;
    localparam int VEC [NV][7] = '{
        '{  20,    0, 4, 5, 0, 0, 4 },  // R4 idle above threshold
        '{  16,  500, 5, 6, 0, 0, 4 },  // R4 idle at threshold wins
        '{  15,  127, 6, 7, 0, 0, 4 },  // R4 memory just below low
        '{   0,  128, 7, 7, 0, 0, 4 },  // R4 memory at low -> hold
        '{   0,  383, 7, 7, 0, 0, 4 },  // R4 memory just below high -> hold
        '{   0,  384, 7, 6, 0, 0, 4 },  // R4 memory at high -> lower
        '{   0, 1000, 7, 5, 1, 0, 8 },  // R8 one pause after previous lower
        '{  30, 1000, 7, 6, 1, 1, 5 },  // R5 raise with paused -> resume
        '{   0,   50, 7, 7, 0, 1, 5 },  // R5 second resume
        '{   0,    0, 7, 8, 0, 0, 6 },  // R6 raise up to ceiling
        '{  40,    0, 8, 8, 0, 0, 6 },  // R6 raise at ceiling ignored
        '{   0, 2040, 8, 7, 0, 0, 4 },  // R4 lower from ceiling
        '{   0, 2040, 8, 6, 1, 0, 8 },  // R8 pause follows lower
        '{   0,  200, 8, 6, 1, 0, 8 },  // R8 another pause, hold
        '{  20,    0, 8, 7, 0, 1, 5 }   // R5 resume on idle raise
    };

    initial begin
        int pz, rz;
        // R1 reset state
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset limit", int'(limit_n), 4);
        chk("R9 reset pause", int'(pause_blk), 0);
        chk("R5 reset resume", int'(resume_blk), 0);
        chk("R3 reset tick", int'(win_tick), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        // the first post-reset edge is window cycle 0; realign with a start pulse
        start_kernel();

        for (int v = 0; v < NV; v++) begin
            run_window(VEC[v][0], VEC[v][1], VEC[v][2], pz, rz);
            chk($sformatf("R%0d row %0d limit", VEC[v][6], v), int'(limit_n), VEC[v][3]);
            chk($sformatf("R%0d row %0d pauses", VEC[v][6], v), pz, VEC[v][4]);
            chk($sformatf("R%0d row %0d resumes", VEC[v][6], v), rz, VEC[v][5]);
        end

        // R2 saturation: two fully loaded windows, second count exceeds 2047
        start_kernel();
        run_window(0, WIN, 0, pz, rz);
        chk("R2 first full window lowers", int'(limit_n), 3);
        run_window(0, WIN, 0, pz, rz);
        chk("R2 saturated count still lowers", int'(limit_n), 2);

        // R7 floor
        run_window(0, 1000, 0, pz, rz);
        chk("R7 lower to floor", int'(limit_n), 1);
        run_window(0, 1000, 0, pz, rz);
        chk("R7 lower at floor ignored", int'(limit_n), 1);

        // R1 mid-window start discards partial counts and restarts the window
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            memwait_evt = 1'b1;
            @(posedge clk);
        end
        start_kernel();
        run_window(0, 200, 0, pz, rz);
        chk("R1 partial counts cleared, hold", int'(limit_n), 4);

        chk("R9 pause and resume together", both_tot, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule